// File: doc/BRIEF.md
# Cable Driver Fault Aggregation and Control

This block sits between a host-visible register file and the datapath of a serial video cable driver. It takes two raw indications from analog comparators: input signal presence and output termination fault. It also takes the enable and edge-rate pins. From these it produces the controls the datapath acts on: effective enable, slow or fast edge rate, the input-offset action and the output-mute action.

It also merges the two fault sources into one active-low open-drain fault line that can be shared by several drivers. Either source can be masked off that line. A sticky status bit for each source lets the host find out which one fired.

The termination result is only meaningful while the driver is enabled and its output has had time to settle. The block therefore gates that result with the effective enable and with a settling counter. The counter runs on the system clock and starts again from zero whenever the effective enable drops.

Top module: `dfc_ctrl`

## Requirements
- R1: While `sig_present_i` is 0 (loss of signal) and `cfg_mask_los_i` is 0, `fault_oe_o` is 1 (line pulled low) in the same cycle.
- R2: A qualified termination fault drives `fault_oe_o` to 1 unless `cfg_mask_term_i` is 1. With both mask bits at 1, `fault_oe_o` stays 0 for any input.
- R3: Each status bit (`stat_los_o`, `stat_term_o`) goes to 1 at the first clock edge where its source is active. It then holds until an edge where `stat_clr_i` is 1 and the source is inactive. A clear issued while the source is active leaves the bit at 1.
- R4: With `cfg_los_mute_i` at 0 (offset action, the reset default of the register), `los_offset_o` follows the loss indication and `mute_o` is 0. With `cfg_los_mute_i` at 1, `mute_o` follows the loss indication and `los_offset_o` is 0.
- R5: The termination fault is qualified only after `SETTLE_CYCLES` consecutive clock edges with `drv_en_o` at 1. It counts as absent while `drv_en_o` is 0, and the settling count restarts from zero whenever `drv_en_o` goes low.
- R6: `drv_en_o` equals `en_pin_i`, except that it is forced to 0 while `cfg_los_link_i` is 1 and `sig_present_i` is 0.
- R7: `slew_slow_o` is 1 whenever `sdhd_pin_i` is 1. While the pin is 0, `slew_slow_o` follows `cfg_sdhd_i`.
- R8: Once settled and enabled, the qualified termination fault follows `term_bad_i` combinationally, so it clears in the same cycle `term_bad_i` returns to 0.
- R9: After reset both status bits are 0, and the settling count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_present_i | input | 1 | Input signal detector, 1 = valid signal, 0 = loss |
| term_bad_i | input | 1 | Raw output termination fault comparator |
| en_pin_i | input | 1 | Enable pin level |
| sdhd_pin_i | input | 1 | Edge-rate pin, 1 = slow edges |
| cfg_mask_los_i | input | 1 | Remove loss of signal from the fault line |
| cfg_mask_term_i | input | 1 | Remove termination fault from the fault line |
| cfg_los_mute_i | input | 1 | Loss action: 0 = add input offset, 1 = mute output |
| cfg_los_link_i | input | 1 | Loss of signal forces the effective enable low |
| cfg_sdhd_i | input | 1 | Register edge-rate select, used while the pin is low |
| stat_clr_i | input | 1 | Clear pulse for the status bits |
| fault_oe_o | output | 1 | Open-drain pull-down enable of the fault line |
| stat_los_o | output | 1 | Sticky loss-of-signal status |
| stat_term_o | output | 1 | Sticky termination fault status |
| drv_en_o | output | 1 | Effective driver enable |
| slew_slow_o | output | 1 | Edge-rate select to the driver, 1 = slow |
| los_offset_o | output | 1 | Apply input offset |
| mute_o | output | 1 | Mute the driver output |

## Verification
The control outputs are swept over every combination of the eight pin and register inputs while no termination fault is present. This separates the masking, linking, loss-action and edge-rate priority terms from one another.

The settling window is stepped one edge at a time across its boundary, both from reset and after an enable drop. This distinguishes an off-by-one count or a missing restart from correct qualification.

Status bits are tried with a single-cycle event, with a clear while the source is inactive, and with a clear while it is still active. These three cases tell set priority apart from clear priority.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
   localparam int NSRC     = 2;
   localparam int SRC_LOS  = 0;
   localparam int SRC_TERM = 1;

   typedef enum logic {
      LOS_ACT_OFFSET = 1'b0,
      LOS_ACT_MUTE   = 1'b1
   } los_act_e;
endpackage

// File: rtl/dfc_settle_timer.sv
module dfc_settle_timer #(
   parameter int SETTLE_CYCLES = 200_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

   initial begin
      if (SETTLE_CYCLES < 1) $error("SETTLE_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run_i)        cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/dfc_fault_combine.sv
module dfc_fault_combine #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt_i,
   input  logic [NSRC-1:0] mask_i,
   input  logic            clr_i,
   output logic            fault_oe_o,
   output logic [NSRC-1:0] sticky_o
);
   initial begin
      if (NSRC < 1) $error("NSRC must be at least 1");
   end

   logic [NSRC-1:0] live;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign live[g] = evt_i[g] & ~mask_i[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sticky_o[g] <= 1'b0;
         else        sticky_o[g] <= (sticky_o[g] & ~clr_i) | evt_i[g];
      end
   end

   assign fault_oe_o = |live;
endmodule

// File: rtl/dfc_ctrl.sv
module dfc_ctrl
   import dfc_pkg::*;
#(
   parameter int SETTLE_CYCLES = 200_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_present_i,
   input  logic term_bad_i,
   input  logic en_pin_i,
   input  logic sdhd_pin_i,
   input  logic cfg_mask_los_i,
   input  logic cfg_mask_term_i,
   input  logic cfg_los_mute_i,
   input  logic cfg_los_link_i,
   input  logic cfg_sdhd_i,
   input  logic stat_clr_i,
   output logic fault_oe_o,
   output logic stat_los_o,
   output logic stat_term_o,
   output logic drv_en_o,
   output logic slew_slow_o,
   output logic los_offset_o,
   output logic mute_o
);
   logic            loss;
   logic            settled;
   logic            term_ok;
   los_act_e        los_act;
   logic [NSRC-1:0] evt;
   logic [NSRC-1:0] mask;
   logic [NSRC-1:0] sticky;

   assign loss     = ~sig_present_i;
   assign drv_en_o = en_pin_i & ~(cfg_los_link_i & loss);

   dfc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (drv_en_o),
      .done_o (settled)
   );

   assign term_ok = term_bad_i & drv_en_o & settled;

   assign evt[SRC_LOS]   = loss;
   assign evt[SRC_TERM]  = term_ok;
   assign mask[SRC_LOS]  = cfg_mask_los_i;
   assign mask[SRC_TERM] = cfg_mask_term_i;

   dfc_fault_combine #(.NSRC(NSRC)) u_comb (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .mask_i     (mask),
      .clr_i      (stat_clr_i),
      .fault_oe_o (fault_oe_o),
      .sticky_o   (sticky)
   );

   assign stat_los_o  = sticky[SRC_LOS];
   assign stat_term_o = sticky[SRC_TERM];

   assign los_act      = los_act_e'(cfg_los_mute_i);
   assign mute_o       = loss & (los_act == LOS_ACT_MUTE);
   assign los_offset_o = loss & (los_act == LOS_ACT_OFFSET);

   assign slew_slow_o = sdhd_pin_i | cfg_sdhd_i;
endmodule

// File: rtl/dfc_ctrl_chk.sv
module dfc_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic sig_present_i,
   input logic term_bad_i,
   input logic en_pin_i,
   input logic sdhd_pin_i,
   input logic cfg_mask_los_i,
   input logic cfg_mask_term_i,
   input logic cfg_los_mute_i,
   input logic cfg_los_link_i,
   input logic cfg_sdhd_i,
   input logic stat_clr_i,
   input logic fault_oe_o,
   input logic stat_los_o,
   input logic stat_term_o,
   input logic drv_en_o,
   input logic slew_slow_o,
   input logic los_offset_o,
   input logic mute_o
);
   AST_LOS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!sig_present_i && !cfg_mask_los_i) |-> fault_oe_o); // R1
   AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask_los_i && cfg_mask_term_i) |-> !fault_oe_o); // R2
   AST_LOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !sig_present_i |=> stat_los_o); // R3
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_los_o && !stat_clr_i) |=> stat_los_o); // R3
   AST_MUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mute_o && los_offset_o)); // R4
   AST_DISABLED_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_en_o && cfg_mask_los_i) |-> !fault_oe_o); // R5
   AST_FRESH_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(drv_en_o) && cfg_mask_los_i) |-> !fault_oe_o); // R5
   AST_LINK_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_los_link_i && !sig_present_i) |-> !drv_en_o); // R6
   AST_PIN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
      sdhd_pin_i |-> slew_slow_o); // R7
endmodule

bind dfc_ctrl dfc_ctrl_chk u_chk (.*);

// File: tb/dfc_ctrl_test.sv
module dfc_ctrl_test;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sig_present_i = 1'b1, term_bad_i = 1'b0, en_pin_i = 1'b1, sdhd_pin_i = 1'b0;
   logic cfg_mask_los_i = 1'b0, cfg_mask_term_i = 1'b0, cfg_los_mute_i = 1'b0;
   logic cfg_los_link_i = 1'b0, cfg_sdhd_i = 1'b0, stat_clr_i = 1'b0;
   logic fault_oe_o, stat_los_o, stat_term_o, drv_en_o, slew_slow_o, los_offset_o, mute_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dfc_ctrl #(.SETTLE_CYCLES(N)) uut (.*);

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) tick();
      rst_n = 1'b1;
      #1;
      // R9 reset state
      chk("R9 stat_los", stat_los_o, 1'b0);
      chk("R9 stat_term", stat_term_o, 1'b0);
      chk("R9 fault", fault_oe_o, 1'b0);

      // R3 sticky loss status
      tick();
      sig_present_i = 1'b0;
      tick();
      sig_present_i = 1'b1;
      #1 chk("R3 los set", stat_los_o, 1'b1);
      tick();
      chk("R3 los hold", stat_los_o, 1'b1);
      stat_clr_i = 1'b1;
      sig_present_i = 1'b0;
      tick();
      chk("R3 clear while active", stat_los_o, 1'b1);
      sig_present_i = 1'b1;
      tick();
      stat_clr_i = 1'b0;
      #1 chk("R3 clear while idle", stat_los_o, 1'b0);

      // exhaustive sweep of combinational controls, no termination fault
      for (int v = 0; v < 256; v++) begin
         logic ls, ml, mt, mu, lk, sp, sr, en, loss;
         {ls, ml, mt, mu, lk, sp, sr, en} = 8'(v);
         sig_present_i = ~ls; cfg_mask_los_i = ml; cfg_mask_term_i = mt;
         cfg_los_mute_i = mu; cfg_los_link_i = lk; sdhd_pin_i = sp;
         cfg_sdhd_i = sr; en_pin_i = en;
         loss = ls;
         #2;
         chk("R1 fault", fault_oe_o, loss & ~ml);
         chk("R6 drv_en", drv_en_o, en & ~(lk & loss));
         chk("R7 slew", slew_slow_o, sp | sr);
         chk("R4 mute", mute_o, loss & mu);
         chk("R4 offset", los_offset_o, loss & ~mu);
      end

      // R5 settle window from a fresh enable
      sig_present_i = 1'b1; cfg_mask_los_i = 1'b0; cfg_mask_term_i = 1'b0;
      cfg_los_link_i = 1'b0; cfg_los_mute_i = 1'b0; sdhd_pin_i = 1'b0; cfg_sdhd_i = 1'b0;
      en_pin_i = 1'b0; term_bad_i = 1'b1;
      tick();
      #1 chk("R5 disabled", fault_oe_o, 1'b0);
      en_pin_i = 1'b1;
      for (int k = 0; k <= N + 2; k++) begin
         #1 chk("R5 window", fault_oe_o, (k >= N));
         tick();
      end
      chk("R3 term sticky", stat_term_o, 1'b1);

      // R8 clears with comparator
      term_bad_i = 1'b0;
      #1 chk("R8 clear", fault_oe_o, 1'b0);
      term_bad_i = 1'b1;
      #1 chk("R8 reassert", fault_oe_o, 1'b1);
      cfg_mask_term_i = 1'b1;
      #1 chk("R2 term masked", fault_oe_o, 1'b0);
      chk("R2 status kept", stat_term_o, 1'b1);
      cfg_mask_term_i = 1'b0;

      // R5 restart after enable drop
      en_pin_i = 1'b0;
      tick();
      en_pin_i = 1'b1;
      for (int k = 0; k <= N; k++) begin
         #1 if (k == 0 || k == N - 1 || k == N)
            chk("R5 restart", fault_oe_o, (k >= N));
         tick();
      end

      // R6 link drops enable, R5 termination gone
      cfg_mask_los_i = 1'b1; cfg_los_link_i = 1'b1; sig_present_i = 1'b0;
      #1 chk("R6 link off", drv_en_o, 1'b0);
      chk("R5 link no term", fault_oe_o, 1'b0);
      cfg_mask_term_i = 1'b1; sig_present_i = 1'b1; cfg_los_link_i = 1'b0;
      #1 chk("R2 both masked", fault_oe_o, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule